// File: doc/BRIEF.md
# Battery-Compensated LED Column Scanner

This block drives a six-column LED matrix by multiplexing. One column is switched on at a time, in a fixed cyclic order, and the block drives that column's row pattern onto the row lines. Each column owns a time slot of 166 timebase ticks. The matrix is lit only during the first part of that slot. During the remainder, every column enable and every row line is inactive.

The lit portion is chosen from a 3-bit battery-level code. A full battery (code 7) gives the shortest lit time. Each step down in the code lengthens the lit time by a fixed amount. This keeps the average light output about the same while the supply voltage falls. The code and the row pattern are both captured at slot boundaries, so neither can change what is shown partway through a slot.

Logic outside the block supplies a one-cycle tick for every 0.1 ms of time, a flattened vector of row patterns (one pattern per column) and the battery-level code.

Top module: `batt_comp_col_scan`

## Requirements
- R1: At most one column enable is high at any time. Successive slots use columns 0,1,2,3,4,5 and then return to 0. Column k is bit k of `col_en`.
- R2: Each slot lasts exactly 166 ticks. The column changes on the tick that ends a slot and on no other tick.
- R3: A slot is lit for exactly T ticks, starting from its first tick. T = 100 + 9×(7 − code) for the 3-bit battery code: code 7 gives 100, code 3 gives 136 and code 0 gives 163.
- R4: T never exceeds 166 − 3 = 163, so every slot has at least 3 blank ticks at its end.
- R5: The battery code is captured only on the tick that opens a slot. A change to the code during a slot alters only the next slot.
- R6: When a slot is not lit, `col_en` and `row_out` are all zero.
- R7: The row pattern for column k is bits [8k+7:8k] of `row_data`. It is captured when the slot of column k opens and is held unchanged on `row_out` for the whole lit part of that slot.
- R8: Synchronous reset makes all outputs zero and clears the tick count. The next scan starts at column 0. That first slot opens on the first tick after reset is released.
- R9: The outputs change only on a clock edge at which `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timebase pulse, one per 0.1 ms |
| row_data | input | 48 | Row patterns, 8 bits per column, column 0 in the low byte |
| batt_level | input | 3 | Battery-level code, 7 = full, 0 = lowest |
| col_en | output | 6 | One-hot column enables, all zero while blank |
| row_out | output | 8 | Row drive for the active column, zero while blank |

## Verification
A column pointer that skips or repeats shows up at the very first tick of the next slot, because the wrong bit of `col_en` lights. A tick counter or a captured lit length that is wrong shows up within the same slot: the count of lit ticks is off, or the light stops at the wrong place. The bench counts lit ticks in each slot and compares the count with the code-derived length. It also changes the code and the row data halfway through a slot to show that the change waits for the next boundary.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Lit length in ticks for a battery code, clamped to keep a minimum blank tail.
  function automatic int dwell_ticks(input int code, input int code_max,
                                     input int full_ticks, input int step_ticks,
                                     input int slot_ticks, input int min_blank);
    int raw;
    int lim;
    raw = full_ticks + (code_max - code) * step_ticks;
    lim = slot_ticks - min_blank;
    if (raw > lim) raw = lim;
    if (raw < 0) raw = 0;
    return raw;
  endfunction

  // Next column index in the rotation.
  function automatic int next_col(input int idx, input int num_cols);
    return (idx >= num_cols - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/bcs_slot_timer.sv
module bcs_slot_timer #(
  parameter int SLOT_TICKS = 166,
  localparam int CNT_W = $clog2(SLOT_TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             slot_start,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_TICKS - 1);

  logic at_last;

  assign at_last    = (cnt == LAST);
  assign wrap       = tick && armed && at_last;
  assign slot_start = tick && (!armed || at_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (tick) begin
      if (!armed) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (at_last) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bcs_col_ring.sv
module bcs_col_ring #(
  parameter int NUM_COLS = 6,
  localparam int SEL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  output logic [SEL_W-1:0]    load_idx,
  output logic [NUM_COLS-1:0] col_oh
);

  logic [SEL_W-1:0] idx;
  logic [SEL_W-1:0] idx_nxt;

  assign idx_nxt  = SEL_W'(bcs_pkg::next_col(int'(idx), NUM_COLS));
  assign load_idx = advance ? idx_nxt : idx;

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (advance) idx <= idx_nxt;
  end

  for (genvar k = 0; k < NUM_COLS; k++) begin : g_dec
    assign col_oh[k] = (idx == SEL_W'(k));
  end

endmodule

// File: rtl/bcs_dwell_sel.sv
module bcs_dwell_sel #(
  parameter int NUM_COLS   = 6,
  parameter int ROWS       = 8,
  parameter int LVL_W      = 3,
  parameter int SLOT_TICKS = 166,
  parameter int ON_FULL    = 100,
  parameter int ON_STEP    = 9,
  parameter int MIN_BLANK  = 3,
  localparam int CNT_W = $clog2(SLOT_TICKS),
  localparam int SEL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int CODE_MAX = (1 << LVL_W) - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [LVL_W-1:0]         level,
  input  logic [NUM_COLS*ROWS-1:0] row_data,
  input  logic [SEL_W-1:0]         load_idx,
  output logic [CNT_W-1:0]         on_len,
  output logic [ROWS-1:0]          row_lat
);

  logic [CNT_W-1:0] on_nxt;
  logic [ROWS-1:0]  row_sel;

  assign on_nxt = CNT_W'(bcs_pkg::dwell_ticks(int'(level), CODE_MAX, ON_FULL,
                                              ON_STEP, SLOT_TICKS, MIN_BLANK));

  always_comb begin
    row_sel = '0;
    for (int k = 0; k < NUM_COLS; k++) begin
      if (load_idx == SEL_W'(k)) row_sel = row_data[k*ROWS +: ROWS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_len  <= '0;
      row_lat <= '0;
    end else if (load) begin
      on_len  <= on_nxt;
      row_lat <= row_sel;
    end
  end

endmodule

// File: rtl/batt_comp_col_scan.sv
module batt_comp_col_scan #(
  parameter int NUM_COLS   = 6,
  parameter int ROWS       = 8,
  parameter int LVL_W      = 3,
  parameter int SLOT_TICKS = 166,
  parameter int ON_FULL    = 100,
  parameter int ON_STEP    = 9,
  parameter int MIN_BLANK  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic [NUM_COLS*ROWS-1:0] row_data,
  input  logic [LVL_W-1:0]         batt_level,
  output logic [NUM_COLS-1:0]      col_en,
  output logic [ROWS-1:0]          row_out
);

  localparam int CNT_W = $clog2(SLOT_TICKS);
  localparam int SEL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

  logic [CNT_W-1:0]    cnt;
  logic                armed;
  logic                slot_start;
  logic                wrap;
  logic [SEL_W-1:0]    load_idx;
  logic [NUM_COLS-1:0] col_oh;
  logic [CNT_W-1:0]    on_len;
  logic [ROWS-1:0]     row_lat;
  logic                lit;

  bcs_slot_timer #(.SLOT_TICKS(SLOT_TICKS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick),
    .cnt(cnt), .armed(armed), .slot_start(slot_start), .wrap(wrap)
  );

  bcs_col_ring #(.NUM_COLS(NUM_COLS)) u_ring (
    .clk(clk), .rst(rst), .advance(wrap),
    .load_idx(load_idx), .col_oh(col_oh)
  );

  bcs_dwell_sel #(
    .NUM_COLS(NUM_COLS), .ROWS(ROWS), .LVL_W(LVL_W), .SLOT_TICKS(SLOT_TICKS),
    .ON_FULL(ON_FULL), .ON_STEP(ON_STEP), .MIN_BLANK(MIN_BLANK)
  ) u_dwell (
    .clk(clk), .rst(rst), .load(slot_start), .level(batt_level),
    .row_data(row_data), .load_idx(load_idx),
    .on_len(on_len), .row_lat(row_lat)
  );

  assign lit     = armed && (cnt < on_len);
  assign col_en  = lit ? col_oh : '0;
  assign row_out = lit ? row_lat : '0;

endmodule

// File: rtl/bcs_scan_chk.sv
module bcs_scan_chk #(
  parameter int NUM_COLS   = 6,
  parameter int ROWS       = 8,
  parameter int SLOT_TICKS = 166,
  parameter int MIN_BLANK  = 3,
  localparam int CNT_W = $clog2(SLOT_TICKS)
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                armed,
  input logic                slot_start,
  input logic                wrap,
  input logic [CNT_W-1:0]    cnt,
  input logic [CNT_W-1:0]    on_len,
  input logic [ROWS-1:0]     row_lat,
  input logic [NUM_COLS-1:0] col_oh,
  input logic                lit,
  input logic [NUM_COLS-1:0] col_en,
  input logic [ROWS-1:0]     row_out
);

  // R1
  one_col_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(col_en));

  // R1
  rotate_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> col_oh == {$past(col_oh[NUM_COLS-2:0]), $past(col_oh[NUM_COLS-1])});

  // R2
  slot_len_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(SLOT_TICKS - 1));

  // R4
  min_blank_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> on_len <= CNT_W'(SLOT_TICKS - MIN_BLANK));

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !slot_start |=> $stable(on_len));

  // R6
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    !lit |-> (col_en == '0 && row_out == '0));

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !slot_start |=> $stable(row_lat));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !armed && col_en == '0 && row_out == '0));

  // R9
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(col_en) && $stable(row_out)));

endmodule

bind batt_comp_col_scan bcs_scan_chk #(
  .NUM_COLS(NUM_COLS), .ROWS(ROWS), .SLOT_TICKS(SLOT_TICKS), .MIN_BLANK(MIN_BLANK)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .armed(armed), .slot_start(slot_start),
  .wrap(wrap), .cnt(cnt), .on_len(on_len), .row_lat(row_lat), .col_oh(col_oh),
  .lit(lit), .col_en(col_en), .row_out(row_out)
);

// File: tb/batt_comp_col_scan_tb.sv
module batt_comp_col_scan_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 6;
  localparam int NR = 8;
  localparam int SLOT = 166;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick = 1'b0;
  logic [NC*NR-1:0] row_data = '0;
  logic [2:0]      batt_level = 3'd7;
  logic [NC-1:0]   col_en;
  logic [NR-1:0]   row_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_col = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_comp_col_scan u_dut (
    .clk(clk), .rst(rst), .tick(tick), .row_data(row_data),
    .batt_level(batt_level), .col_en(col_en), .row_out(row_out)
  );

  function automatic int exp_on(input int code);
    int v;
    v = 163 - 9 * code;
    if (v > SLOT - 3) v = SLOT - 3;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // One full slot: expected column, lit length and row pattern; optional mid-slot change.
  task automatic run_slot(input int on_exp, input logic [NR-1:0] rows_exp,
                          input bit mid, input logic [2:0] mid_lvl,
                          input logic [NC*NR-1:0] mid_rows);
    int lit_cnt = 0;
    int bad_col = 0, bad_row = 0, bad_blank = 0, bad_shape = 0;
    for (int i = 0; i < SLOT; i++) begin
      do_tick();
      if (mid && i == 40) begin
        batt_level = mid_lvl;
        row_data = mid_rows;
      end
      if (col_en != '0) begin
        lit_cnt++;
        if (col_en != NC'(1 << exp_col)) bad_col++;
        if (row_out != rows_exp) bad_row++;
        if (i >= on_exp) bad_shape++;
      end else begin
        if (row_out != '0) bad_blank++;
        if (i < on_exp) bad_shape++;
      end
    end
    check(bad_col == 0, "R1/R2", "wrong column samples", bad_col, 0);
    check(lit_cnt == on_exp, "R3", "lit ticks in slot", lit_cnt, on_exp);
    check(bad_shape == 0, "R3", "lit not a prefix of slot", bad_shape, 0);
    check(bad_blank == 0, "R6", "rows active while blank", bad_blank, 0);
    check(bad_row == 0, "R7", "row pattern mismatches", bad_row, 0);
    exp_col = (exp_col + 1) % NC;
  endtask

  function automatic logic [NR-1:0] rows_of(input logic [NC*NR-1:0] d, input int c);
    return d[c*NR +: NR];
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(col_en == '0, "R8", "col_en after reset", int'(col_en), 0);
    check(row_out == '0, "R8", "row_out after reset", int'(row_out), 0);
    exp_col = 0;
  endtask

  task automatic t_full_scan();
    batt_level = 3'd7;
    for (int c = 0; c < NC; c++) run_slot(exp_on(7), rows_of(row_data, exp_col), 0, 0, '0);
    // R1 wrap back to column 0
    run_slot(exp_on(7), rows_of(row_data, exp_col), 0, 0, '0);
  endtask

  task automatic t_low_batt();
    batt_level = 3'd0;
    // R4 lowest code leaves exactly 3 blank ticks
    check(exp_on(0) == 163, "R4", "model on-time at code 0", exp_on(0), 163);
    run_slot(163, rows_of(row_data, exp_col), 0, 0, '0);
    run_slot(163, rows_of(row_data, exp_col), 0, 0, '0);
  endtask

  task automatic t_mid_change();
    logic [NC*NR-1:0] new_rows;
    new_rows = ~row_data ^ 48'h5a5a_1234_8001;
    batt_level = 3'd3;
    // R5 and R7: change mid-slot, current slot keeps 136 ticks and old rows
    run_slot(136, rows_of(row_data, exp_col), 1, 3'd0, new_rows);
    run_slot(163, rows_of(new_rows, exp_col), 0, 0, '0);
  endtask

  task automatic t_hold();
    logic [NC-1:0] c0;
    logic [NR-1:0] r0;
    int chg = 0;
    batt_level = 3'd5;
    do_tick();
    c0 = col_en;
    r0 = row_out;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (col_en != c0 || row_out != r0) chg++;
    end
    check(chg == 0, "R9", "outputs changed without tick", chg, 0);
    check(col_en == NC'(1 << exp_col), "R1", "column at hold", int'(col_en), 1 << exp_col);
    check(row_out == rows_of(row_data, exp_col), "R7", "rows at hold",
          int'(row_out), int'(rows_of(row_data, exp_col)));
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 10; i++) do_tick();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check(col_en == '0 && row_out == '0, "R8", "outputs during reset",
          int'(col_en), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(col_en == '0, "R8", "blank before first tick", int'(col_en), 0);
    exp_col = 0;
    batt_level = 3'd6;
    run_slot(exp_on(6), rows_of(row_data, 0), 0, 0, '0);
    run_slot(exp_on(6), rows_of(row_data, 1), 0, 0, '0);
  endtask

  initial begin
    row_data = 48'hc3_81_7e_3c_a5_0f;
    t_reset();
    t_full_scan();
    t_low_batt();
    t_mid_change();
    t_hold();
    t_reset_mid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule